// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

The controller gathers eight level-sensitive interrupt request lines, samples them into a request register, filters them through a mask and picks one winner. A single interrupt line tells the processor that a request is waiting. When the processor acknowledges, the controller returns the 3-bit number of the winning level and marks that level as being serviced. Software later retires the level with an end-of-interrupt command.

The priority order comes from a 3-bit pointer that names the lowest-priority level. The remaining levels rank upward in numerical order from the level just above it, wrapping round. Software selects one of three schemes at run time:
- In fixed mode the pointer is held at 7.
- In rotating mode a retired level becomes the new lowest.
- In specific mode software writes the lowest level directly.

The request, in-service and mask registers and the mode and pointer can be read through a small select port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and `level_o` is 0. The request, in-service and mask registers are all zero, the mode is fixed and the pointer is 0, so every readback select returns 0.
- R2: The request register takes the value of `req_i` on each clock edge. It is read with `rd_sel_i` = 0.
- R3: Command op 1 writes `cmd_arg_i` into the mask register, which is read with `rd_sel_i` = 2. A level whose mask bit is 1 never raises `irq_o` and is never returned on acknowledge.
- R4: In fixed mode (mode code 0), level 0 ranks highest and level 7 lowest.
- R5: An `ack_i` pulse while `irq_o` is 1 puts the winning level on `level_o` after the clock edge and sets its bit in the in-service register, which is read with `rd_sel_i` = 1.
- R6: `irq_o` is 1 only when some unmasked request ranks strictly above every level that is currently in service.
- R7: Command op 3 (non-specific end of interrupt) clears the in-service bit that ranks highest under the current order.
- R8: Command op 4 (specific end of interrupt) clears the in-service bit numbered by `cmd_arg_i[2:0]`.
- R9: In rotating mode (mode code 1), op 3 also moves the lowest-priority pointer to the level it cleared.
- R10: Command op 2 loads the mode from `cmd_arg_i[1:0]` and the pointer from `cmd_arg_i[4:2]`. In specific mode (mode code 2), the level after the pointer ranks highest, and op 3 leaves the pointer unchanged. `rd_sel_i` = 3 returns {3'b000, pointer, mode}. Mode code 3 behaves as fixed.
- R11: An `ack_i` pulse while `irq_o` is 0 returns level 7 and sets no in-service bit.
- R12: When an acknowledge and an end-of-interrupt command fall in the same cycle, both take effect. The acknowledge picks its winner under the order and in-service state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines, level sensitive |
| ack_i | input | 1 | Processor acknowledge, one cycle |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code: 1 mask, 2 mode, 3 non-specific EOI, 4 specific EOI |
| cmd_arg_i | input | 8 | Command argument |
| rd_sel_i | input | 2 | Readback select |
| rd_data_o | output | 8 | Selected register contents |
| irq_o | output | 1 | Interrupt request to the processor |
| level_o | output | 3 | Level returned by the last acknowledge |

## Verification
The two functions that can collide are an acknowledge and an end-of-interrupt command in the same clock cycle. The retired level and the newly granted level then meet in the in-service register, and in rotating mode the pointer also moves. A directed case sets up rotating mode with level 2 in service and a higher request on level 1. It then pulses both strobes together and judges the returned level, the resulting in-service bits and the new pointer. Random traffic pulses `ack_i` and `cmd_valid_i` independently, so the collision recurs under every mode. Each cycle is compared with a bench model that applies the retirement first and then grants under the order from before the edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        PM_FIXED    = 2'd0,
        PM_ROTATE   = 2'd1,
        PM_SPECIFIC = 2'd2,
        PM_SPARE    = 2'd3
    } prio_mode_e;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_MASK   = 3'd1,
        OP_MODE   = 3'd2,
        OP_EOI_NS = 3'd3,
        OP_EOI_SP = 3'd4
    } cmd_op_e;

endpackage

// File: rtl/irqc_prio_pick.sv
// Finds the highest-ranked set bit of vec; the level after `low` ranks first.
module irqc_prio_pick #(
    parameter int N_LEVELS = 8,
    localparam int LW = $clog2(N_LEVELS)
) (
    input  logic [N_LEVELS-1:0] vec,
    input  logic [LW-1:0]       low,
    output logic                any,
    output logic [LW-1:0]       idx,
    output logic [LW-1:0]       rank
);
    logic [LW-1:0] pos;

    always_comb begin
        any  = 1'b0;
        idx  = '1;
        rank = '1;
        pos  = '0;
        for (int k = N_LEVELS - 1; k >= 0; k--) begin
            pos = low + LW'(1) + LW'(k);
            if (vec[pos]) begin
                any  = 1'b1;
                idx  = pos;
                rank = LW'(k);
            end
        end
    end
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback #(
    parameter int N_LEVELS = 8,
    localparam int LW = $clog2(N_LEVELS)
) (
    input  logic [1:0]          sel,
    input  logic [N_LEVELS-1:0] irr,
    input  logic [N_LEVELS-1:0] isr,
    input  logic [N_LEVELS-1:0] mask,
    input  logic [1:0]          mode,
    input  logic [LW-1:0]       low,
    output logic [N_LEVELS-1:0] data
);
    always_comb begin
        data = '0;
        case (sel)
            2'd0: data = irr;
            2'd1: data = isr;
            2'd2: data = mask;
            default: begin
                data[1:0]    = mode;
                data[LW+1:2] = low;
            end
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_LEVELS = 8,
    localparam int LW = $clog2(N_LEVELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LEVELS-1:0] req_i,
    input  logic                ack_i,
    input  logic                cmd_valid_i,
    input  logic [2:0]          cmd_op_i,
    input  logic [N_LEVELS-1:0] cmd_arg_i,
    input  logic [1:0]          rd_sel_i,
    output logic [N_LEVELS-1:0] rd_data_o,
    output logic                irq_o,
    output logic [LW-1:0]       level_o
);
    typedef struct packed {
        logic [N_LEVELS-1:0] irr;
        logic [N_LEVELS-1:0] isr;
        logic [N_LEVELS-1:0] mask;
        prio_mode_e          mode;
        logic [LW-1:0]       low;
        logic [LW-1:0]       level;
    } state_t;

    state_t st_d, st_q;

    logic [LW-1:0]       eff_low;
    logic                pend_any, isr_any, grant;
    logic [LW-1:0]       pend_idx, pend_rank, isr_idx, isr_rank;
    logic [N_LEVELS-1:0] set_v, clr_v;

    assign eff_low = (st_q.mode == PM_ROTATE || st_q.mode == PM_SPECIFIC) ? st_q.low : '1;

    irqc_prio_pick #(.N_LEVELS(N_LEVELS)) u_pick_pend (
        .vec(st_q.irr & ~st_q.mask), .low(eff_low),
        .any(pend_any), .idx(pend_idx), .rank(pend_rank)
    );

    irqc_prio_pick #(.N_LEVELS(N_LEVELS)) u_pick_isr (
        .vec(st_q.isr), .low(eff_low),
        .any(isr_any), .idx(isr_idx), .rank(isr_rank)
    );

    // A request is forwarded only when it outranks every in-service level.
    assign grant = pend_any && (!isr_any || pend_rank < isr_rank);
    assign irq_o   = grant;
    assign level_o = st_q.level;

    always_comb begin
        st_d     = st_q;
        st_d.irr = req_i;
        set_v    = '0;
        clr_v    = '0;
        if (ack_i) begin
            if (grant) begin
                set_v[pend_idx] = 1'b1;
                st_d.level      = pend_idx;
            end else begin
                st_d.level = '1;
            end
        end
        if (cmd_valid_i) begin
            case (cmd_op_e'(cmd_op_i))
                OP_MASK: st_d.mask = cmd_arg_i;
                OP_MODE: begin
                    st_d.mode = prio_mode_e'(cmd_arg_i[1:0]);
                    st_d.low  = cmd_arg_i[LW+1:2];
                end
                OP_EOI_NS: begin
                    if (isr_any) begin
                        clr_v[isr_idx] = 1'b1;
                        if (st_q.mode == PM_ROTATE) st_d.low = isr_idx;
                    end
                end
                OP_EOI_SP: clr_v[cmd_arg_i[LW-1:0]] = 1'b1;
                default: ;
            endcase
        end
        st_d.isr = (st_q.isr & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irqc_readback #(.N_LEVELS(N_LEVELS)) u_readback (
        .sel(rd_sel_i), .irr(st_q.irr), .isr(st_q.isr), .mask(st_q.mask),
        .mode(st_q.mode), .low(st_q.low), .data(rd_data_o)
    );

    // ---------------- assertions ----------------
    logic [N_LEVELS-1:0] at_or_above;
    always_comb begin
        for (int i = 0; i < N_LEVELS; i++) at_or_above[i] = (i <= int'(pend_idx));
    end

    assert_irq_needs_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((st_q.irr & ~st_q.mask) != '0));

    assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == OP_MASK) |=> st_q.mask == $past(cmd_arg_i));

    assert_ack_marks_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> st_q.isr[st_q.level]);

    assert_fixed_nesting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && st_q.mode == PM_FIXED) |-> (st_q.isr & at_or_above) == '0);

    assert_eoi_ns_clears_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == OP_EOI_NS && st_q.isr != '0 && !ack_i)
        |=> $countones(st_q.isr) == $countones($past(st_q.isr)) - 1);

    assert_empty_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !cmd_valid_i)
        |=> (level_o == '1 && st_q.isr == $past(st_q.isr)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_op_i = '0;
    logic [7:0] cmd_arg_i = '0;
    logic [1:0] rd_sel_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;
    logic [2:0] level_o;

    int n_chk = 0;
    int n_fail = 0;
    bit compare_model = 1'b0;

    logic [7:0] m_irr, m_isr, m_mask;
    logic [1:0] m_mode;
    logic [2:0] m_low, m_level;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_arg_i(cmd_arg_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .level_o(level_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Highest-ranked set bit; the level after lo ranks first.
    function automatic void pick(input logic [7:0] v, input logic [2:0] lo,
                                 output bit any, output logic [2:0] idx, output logic [2:0] rk);
        any = 0; idx = 3'd7; rk = 3'd7;
        for (int k = 7; k >= 0; k--) begin
            logic [2:0] p;
            p = lo + 3'd1 + 3'(k);
            if (v[p]) begin any = 1; idx = p; rk = 3'(k); end
        end
    endfunction

    function automatic logic [2:0] m_eff();
        return (m_mode == 2'd1 || m_mode == 2'd2) ? m_low : 3'd7;
    endfunction

    function automatic bit m_grant(output logic [2:0] win);
        bit pa, ia;
        logic [2:0] pr, ii, ir;
        pick(m_irr & ~m_mask, m_eff(), pa, win, pr);
        pick(m_isr, m_eff(), ia, ii, ir);
        return pa && (!ia || pr < ir);
    endfunction

    task automatic model_edge();
        logic [2:0] win, ii, ir;
        bit g, ia;
        logic [7:0] set_v, clr_v;
        logic [1:0] n_mode;
        logic [2:0] n_low;
        g = m_grant(win);
        pick(m_isr, m_eff(), ia, ii, ir);
        set_v = 0; clr_v = 0; n_mode = m_mode; n_low = m_low;
        if (ack_i) begin
            if (g) begin set_v[win] = 1; m_level = win; end
            else m_level = 3'd7;
        end
        if (cmd_valid_i) begin
            case (cmd_op_i)
                3'd1: m_mask = cmd_arg_i;
                3'd2: begin n_mode = cmd_arg_i[1:0]; n_low = cmd_arg_i[4:2]; end
                3'd3: if (ia) begin clr_v[ii] = 1; if (m_mode == 2'd1) n_low = ii; end
                3'd4: clr_v[cmd_arg_i[2:0]] = 1;
                default: ;
            endcase
        end
        m_isr = (m_isr & ~clr_v) | set_v;
        m_mode = n_mode; m_low = n_low;
        m_irr = req_i;
    endtask

    function automatic logic [7:0] m_rd(input logic [1:0] s);
        case (s)
            2'd0: return m_irr;
            2'd1: return m_isr;
            2'd2: return m_mask;
            default: return {3'b000, m_low, m_mode};
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic [7:0] rq, input bit ak, input bit cv,
                        input logic [2:0] op, input logic [7:0] arg);
        logic [2:0] w;
        req_i = rq; ack_i = ak; cmd_valid_i = cv; cmd_op_i = op; cmd_arg_i = arg;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ack_i = 0; cmd_valid_i = 0;
        if (compare_model) begin
            rd_sel_i = 2'($urandom_range(0, 3));
            #0.5;
            check("R6 irq vs model", {7'd0, irq_o}, {7'd0, m_grant(w)});
            check("R5 level vs model", {5'd0, level_o}, {5'd0, m_level});
            check("R2 readback vs model", rd_data_o, m_rd(rd_sel_i));
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        rd_sel_i = s; #0.5; v = rd_data_o;
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        m_irr = 0; m_isr = 0; m_mask = 0; m_mode = 0; m_low = 0; m_level = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.5;
        check("R1 irq after reset", {7'd0, irq_o}, 8'd0);
        check("R1 level after reset", {5'd0, level_o}, 8'd0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 readback after reset", v, 8'd0);
        end

        // fixed mode, nesting
        step(8'h90, 0, 0, 0, 0);
        rd(0, v); check("R2 request register", v, 8'h90);
        check("R4 irq with requests", {7'd0, irq_o}, 8'd1);
        step(8'h90, 1, 0, 0, 0);
        check("R4 fixed winner level 4", {5'd0, level_o}, 8'd4);
        rd(1, v); check("R5 isr after ack", v, 8'h10);
        check("R6 equal/lower blocked", {7'd0, irq_o}, 8'd0);
        step(8'h94, 0, 0, 0, 0);
        check("R6 higher level forwarded", {7'd0, irq_o}, 8'd1);
        step(8'h94, 1, 0, 0, 0);
        check("R5 nested ack level 2", {5'd0, level_o}, 8'd2);
        rd(1, v); check("R5 isr two levels", v, 8'h14);
        step(8'h94, 0, 1, 3'd3, 0);
        rd(1, v); check("R7 non-specific EOI clears level 2", v, 8'h10);
        step(8'h94, 0, 1, 3'd4, 8'd4);
        rd(1, v); check("R8 specific EOI clears level 4", v, 8'h00);

        // mask
        step(8'h94, 0, 1, 3'd1, 8'h14);
        rd(2, v); check("R3 mask readback", v, 8'h14);
        step(8'h94, 1, 0, 0, 0);
        check("R3 masked levels skipped", {5'd0, level_o}, 8'd7);
        step(8'h94, 0, 1, 3'd4, 8'd7);
        step(8'h94, 0, 1, 3'd1, 8'hFF);
        check("R3 all masked no irq", {7'd0, irq_o}, 8'd0);
        step(8'h94, 0, 1, 3'd1, 8'h00);

        // request vanishes before ack
        step(8'h08, 0, 0, 0, 0);
        step(8'h00, 0, 0, 0, 0);
        step(8'h00, 1, 0, 0, 0);
        check("R11 empty ack level 7", {5'd0, level_o}, 8'd7);
        rd(1, v); check("R11 empty ack no isr", v, 8'h00);

        // rotating mode
        step(8'h09, 0, 1, 3'd2, 8'h1D);
        rd(3, v); check("R10 mode readback rotate", v, 8'h1D);
        step(8'h09, 1, 0, 0, 0);
        check("R9 rotate first winner 0", {5'd0, level_o}, 8'd0);
        step(8'h09, 0, 1, 3'd3, 0);
        rd(3, v); check("R9 pointer moved to 0", v, 8'h01);
        step(8'h09, 1, 0, 0, 0);
        check("R9 rotated winner 3", {5'd0, level_o}, 8'd3);
        step(8'h09, 0, 1, 3'd3, 0);
        step(8'h09, 1, 0, 0, 0);
        check("R9 rotated winner 0 after 3", {5'd0, level_o}, 8'd0);
        step(8'h09, 0, 1, 3'd3, 0);

        // specific priority
        step(8'h41, 0, 1, 3'd2, 8'h16);
        step(8'h41, 1, 0, 0, 0);
        check("R10 specific winner 6", {5'd0, level_o}, 8'd6);
        step(8'h41, 0, 1, 3'd3, 0);
        rd(1, v); check("R10 EOI in specific mode", v, 8'h00);
        rd(3, v); check("R10 pointer held", v, 8'h16);

        // ack and EOI in the same cycle
        step(8'h04, 0, 1, 3'd2, 8'h1D);
        step(8'h04, 1, 0, 0, 0);
        step(8'h06, 0, 0, 0, 0);
        check("R12 setup irq", {7'd0, irq_o}, 8'd1);
        step(8'h06, 1, 1, 3'd3, 0);
        check("R12 level on collision", {5'd0, level_o}, 8'd1);
        rd(1, v); check("R12 isr on collision", v, 8'h02);
        rd(3, v); check("R12 pointer on collision", v, 8'h09);

        // random traffic against the model
        compare_model = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            logic [7:0] arg;
            op = 3'($urandom_range(0, 4));
            arg = 8'($urandom);
            if (op == 3'd1) arg = arg & 8'($urandom);
            step(8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), op, arg);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule